// File: doc/BRIEF.md
# Polyphase Coefficient RAM Loader

This block is the coefficient store that sits beside a polyphase image scaler. Software fills it through three write strobes: one that sets a write pointer (filter type, phase, tap pair), one that sets the tap count used by each filter type, and one that delivers a coefficient pair. Each pair write lands at the pointer and then moves the pointer forward, first across the tap pairs of one phase and then to the next phase. Software therefore only sets the pointer once and then streams the words for a whole filter.

Four independent banks are held: luma horizontal, luma vertical, chroma horizontal and chroma vertical. Each bank is indexed by the filter type code 0, 1, 2 and 3 in that order. The filter is symmetric over 64 phases, so each bank keeps only phases 0 to 32, with up to four tap pairs per phase. A pair word carries an even and an odd coefficient, and each half has its own write enable. The scaler datapath reads a pair back by type, phase and pair, and the result appears one clock later.

Top module: `coef_ram_loader`

## Requirements
- R1: After synchronous reset, every stored coefficient reads as zero, the pointer is type 0, phase 0, pair 0, and every tap-count field holds 7, which means 8 taps and 4 pairs.
- R2: A select write loads the pointer's type, phase and pair from `sel_type`, `sel_phase` and `sel_pair`. A pair write in the same cycle is dropped and does not move the pointer.
- R3: A pair write stores the even half at the pointer only when `even_en` is 1, and the odd half only when `odd_en` is 1. A half whose enable is 0 keeps its previous value.
- R4: The field `tap_data[3t+2:3t]` holds the tap count minus one for type t. The pair count is field/2+1. After each accepted pair write the pair index increments. When the incremented index reaches or passes the pair count of the current type, the pair index wraps to 0 and the phase increments.
- R5: When the tap count of the current type is odd (the field is even), an odd half written at the last pair (pair count minus one) is stored as zero, whatever `odd_coef` holds.
- R6: Bits 1:0 of every coefficient read back are zero.
- R7: When the pointer's phase is 33 or more, reached either by advancing past phase 32 or by a select write, pair writes change no stored value and leave the pointer unchanged.
- R8: The read port samples `rd_type`, `rd_phase` and `rd_pair` at a clock edge and presents the pair after that edge, keeping the previous output until then. A read phase of 33 or more returns zero.
- R9: A write to one filter type leaves the coefficients of the other three types unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_wr | input | 1 | Select write strobe, loads the pointer |
| sel_type | input | 2 | Filter type for the pointer |
| sel_phase | input | 6 | Phase for the pointer |
| sel_pair | input | 2 | Tap pair for the pointer |
| tap_wr | input | 1 | Tap-count write strobe |
| tap_data | input | 12 | Four 3-bit fields of taps minus one, type t at bits [3t+2:3t] |
| data_wr | input | 1 | Pair write strobe |
| even_coef | input | 14 | Even-tap coefficient, signed |
| even_en | input | 1 | Enable for the even half |
| odd_coef | input | 14 | Odd-tap coefficient, signed |
| odd_en | input | 1 | Enable for the odd half |
| rd_type | input | 2 | Read filter type |
| rd_phase | input | 6 | Read phase |
| rd_pair | input | 2 | Read tap pair |
| rd_even | output | 14 | Even coefficient read, one cycle after the address |
| rd_odd | output | 14 | Odd coefficient read, one cycle after the address |

## Verification
The bench builds the block with its default parameters: 14-bit coefficients, 64 full phases (33 stored) and up to 8 taps. With these values every tap count from 1 to 8 can be programmed, so all four pair counts and both odd and even tap parity occur. The walk past phase 32 into the ignored region also takes only a few writes. Random tap counts and coefficient words fill whole banks, and directed writes check colliding strobes, half enables and out-of-range phases, both for the pointer and for reads.

// File: rtl/cram_pkg.sv
`timescale 1ns/1ps
package cram_pkg;

    // Filter type codes; the code is the bank index.
    typedef enum logic [1:0] {
        FT_LUMA_H   = 2'd0,
        FT_LUMA_V   = 2'd1,
        FT_CHROMA_H = 2'd2,
        FT_CHROMA_V = 2'd3
    } ftype_e;

    localparam int NUM_FTYPES = 4;

    // Tap-count field holds taps minus one; pairs = ceil(taps/2).
    function automatic int pairs_of(input int tap_field);
        return tap_field / 2 + 1;
    endfunction

    // True when the tap count (field + 1) is odd.
    function automatic logic taps_are_odd(input int tap_field);
        return (tap_field % 2) == 0;
    endfunction

endpackage

// File: rtl/cram_index_seq.sv
`timescale 1ns/1ps
module cram_index_seq #(
    parameter int STORED  = 33,
    parameter int PHASE_W = 6,
    parameter int PAIR_W  = 2,
    parameter int CNT_W   = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel_wr,
    input  cram_pkg::ftype_e     sel_type,
    input  logic [PHASE_W-1:0]   sel_phase,
    input  logic [PAIR_W-1:0]    sel_pair,
    input  logic                 data_wr,
    input  logic [CNT_W-1:0]     pair_cnt,
    output cram_pkg::ftype_e     idx_type,
    output logic [PHASE_W-1:0]   idx_phase,
    output logic [PAIR_W-1:0]    idx_pair,
    output logic                 wr_go
);

    typedef struct packed {
        cram_pkg::ftype_e    ftype;
        logic [PHASE_W-1:0]  phase;
        logic [PAIR_W-1:0]   pair;
    } ptr_t;

    ptr_t cur_q, cur_d;
    logic [CNT_W-1:0] pair_inc;

    assign pair_inc = CNT_W'(cur_q.pair) + CNT_W'(1);
    // Select has priority; writes beyond the stored phases are dropped.
    assign wr_go    = data_wr && !sel_wr && (int'(cur_q.phase) < STORED);

    always_comb begin
        cur_d = cur_q;
        if (sel_wr) begin
            cur_d.ftype = sel_type;
            cur_d.phase = sel_phase;
            cur_d.pair  = sel_pair;
        end else if (wr_go) begin
            if (pair_inc >= pair_cnt) begin
                cur_d.pair  = '0;
                cur_d.phase = cur_q.phase + PHASE_W'(1);
            end else begin
                cur_d.pair  = PAIR_W'(pair_inc);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.ftype <= cram_pkg::FT_LUMA_H;
            cur_q.phase <= '0;
            cur_q.pair  <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign idx_type  = cur_q.ftype;
    assign idx_phase = cur_q.phase;
    assign idx_pair  = cur_q.pair;

endmodule

// File: rtl/cram_bank.sv
`timescale 1ns/1ps
module cram_bank #(
    parameter int STORED    = 33,
    parameter int MAX_PAIRS = 4,
    parameter int STORE_W   = 12,
    parameter int PHASE_W   = 6,
    parameter int PAIR_W    = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we_even,
    input  logic                we_odd,
    input  logic [PHASE_W-1:0]  wr_phase,
    input  logic [PAIR_W-1:0]   wr_pair,
    input  logic [STORE_W-1:0]  wr_even,
    input  logic [STORE_W-1:0]  wr_odd,
    input  logic [PHASE_W-1:0]  rd_phase,
    input  logic [PAIR_W-1:0]   rd_pair,
    output logic [STORE_W-1:0]  rd_even,
    output logic [STORE_W-1:0]  rd_odd
);

    logic [STORE_W-1:0] mem_e [STORED][MAX_PAIRS];
    logic [STORE_W-1:0] mem_o [STORED][MAX_PAIRS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < STORED; p++) begin
                for (int q = 0; q < MAX_PAIRS; q++) begin
                    mem_e[p][q] <= '0;
                    mem_o[p][q] <= '0;
                end
            end
        end else begin
            if (we_even) mem_e[wr_phase][wr_pair] <= wr_even;
            if (we_odd)  mem_o[wr_phase][wr_pair] <= wr_odd;
        end
    end

    always_comb begin
        rd_even = '0;
        rd_odd  = '0;
        if (int'(rd_phase) < STORED) begin
            rd_even = mem_e[rd_phase][rd_pair];
            rd_odd  = mem_o[rd_phase][rd_pair];
        end
    end

endmodule

// File: rtl/coef_ram_loader.sv
`timescale 1ns/1ps
module coef_ram_loader
    import cram_pkg::*;
#(
    parameter int COEF_W      = 14,
    parameter int FULL_PHASES = 64,
    parameter int MAX_TAPS    = 8,
    parameter int LSB_ZERO    = 2,
    localparam int STORED     = FULL_PHASES / 2 + 1,
    localparam int MAX_PAIRS  = (MAX_TAPS + 1) / 2,
    localparam int PHASE_W    = $clog2(STORED),
    localparam int PAIR_W     = (MAX_PAIRS > 1) ? $clog2(MAX_PAIRS) : 1,
    localparam int TAPF_W     = $clog2(MAX_TAPS),
    localparam int TAPCTL_W   = NUM_FTYPES * TAPF_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel_wr,
    input  logic [1:0]           sel_type,
    input  logic [PHASE_W-1:0]   sel_phase,
    input  logic [PAIR_W-1:0]    sel_pair,
    input  logic                 tap_wr,
    input  logic [TAPCTL_W-1:0]  tap_data,
    input  logic                 data_wr,
    input  logic [COEF_W-1:0]    even_coef,
    input  logic                 even_en,
    input  logic [COEF_W-1:0]    odd_coef,
    input  logic                 odd_en,
    input  logic [1:0]           rd_type,
    input  logic [PHASE_W-1:0]   rd_phase,
    input  logic [PAIR_W-1:0]    rd_pair,
    output logic [COEF_W-1:0]    rd_even,
    output logic [COEF_W-1:0]    rd_odd
);

    localparam int CNT_W   = $clog2(MAX_PAIRS + 1);
    localparam int STORE_W = COEF_W - LSB_ZERO;

    // Tap-count registers, one per filter type
    logic [TAPF_W-1:0] tapf_q [NUM_FTYPES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < NUM_FTYPES; t++) tapf_q[t] <= TAPF_W'(MAX_TAPS - 1);
        end else if (tap_wr) begin
            for (int t = 0; t < NUM_FTYPES; t++) tapf_q[t] <= tap_data[t*TAPF_W +: TAPF_W];
        end
    end

    // Write pointer
    ftype_e             idx_type;
    logic [PHASE_W-1:0] idx_phase;
    logic [PAIR_W-1:0]  idx_pair;
    logic               wr_go;
    logic [CNT_W-1:0]   pair_cnt;
    logic [TAPF_W-1:0]  cur_field;
    logic               last_odd_zero;

    assign cur_field     = tapf_q[idx_type];
    assign pair_cnt      = CNT_W'(pairs_of(int'(cur_field)));
    assign last_odd_zero = taps_are_odd(int'(cur_field))
                        && ((CNT_W'(idx_pair) + CNT_W'(1)) == pair_cnt);

    cram_index_seq #(
        .STORED  (STORED),
        .PHASE_W (PHASE_W),
        .PAIR_W  (PAIR_W),
        .CNT_W   (CNT_W)
    ) seq_i (
        .clk       (clk),
        .rst       (rst),
        .sel_wr    (sel_wr),
        .sel_type  (ftype_e'(sel_type)),
        .sel_phase (sel_phase),
        .sel_pair  (sel_pair),
        .data_wr   (data_wr),
        .pair_cnt  (pair_cnt),
        .idx_type  (idx_type),
        .idx_phase (idx_phase),
        .idx_pair  (idx_pair),
        .wr_go     (wr_go)
    );

    // Only the upper coefficient bits are kept; the low bits are implied zero.
    logic [STORE_W-1:0] wdat_even, wdat_odd;
    assign wdat_even = even_coef[COEF_W-1:LSB_ZERO];
    assign wdat_odd  = last_odd_zero ? '0 : odd_coef[COEF_W-1:LSB_ZERO];

    logic [STORE_W-1:0] bank_e [NUM_FTYPES];
    logic [STORE_W-1:0] bank_o [NUM_FTYPES];

    for (genvar g = 0; g < NUM_FTYPES; g++) begin : g_bank
        logic hit;
        assign hit = wr_go && (idx_type == ftype_e'(g));

        cram_bank #(
            .STORED    (STORED),
            .MAX_PAIRS (MAX_PAIRS),
            .STORE_W   (STORE_W),
            .PHASE_W   (PHASE_W),
            .PAIR_W    (PAIR_W)
        ) bank_i (
            .clk      (clk),
            .rst      (rst),
            .we_even  (hit && even_en),
            .we_odd   (hit && odd_en),
            .wr_phase (idx_phase),
            .wr_pair  (idx_pair),
            .wr_even  (wdat_even),
            .wr_odd   (wdat_odd),
            .rd_phase (rd_phase),
            .rd_pair  (rd_pair),
            .rd_even  (bank_e[g]),
            .rd_odd   (bank_o[g])
        );
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_even <= '0;
            rd_odd  <= '0;
        end else begin
            rd_even <= {bank_e[rd_type], {LSB_ZERO{1'b0}}};
            rd_odd  <= {bank_o[rd_type], {LSB_ZERO{1'b0}}};
        end
    end

endmodule

// File: rtl/cram_checker.sv
`timescale 1ns/1ps
module cram_checker #(
    parameter int STORED   = 33,
    parameter int PHASE_W  = 6,
    parameter int PAIR_W   = 2,
    parameter int COEF_W   = 14,
    parameter int LSB_ZERO = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               sel_wr,
    input logic [1:0]         sel_type,
    input logic [PHASE_W-1:0] sel_phase,
    input logic [PAIR_W-1:0]  sel_pair,
    input logic               data_wr,
    input logic [PHASE_W-1:0] rd_phase,
    input logic [COEF_W-1:0]  rd_even,
    input logic [COEF_W-1:0]  rd_odd,
    input logic [1:0]         idx_type,
    input logic [PHASE_W-1:0] idx_phase,
    input logic [PAIR_W-1:0]  idx_pair
);

    assert_sel_load_R2: assert property (@(posedge clk) disable iff (rst)
        sel_wr |=> (idx_type == $past(sel_type)) && (idx_phase == $past(sel_phase))
                && (idx_pair == $past(sel_pair)));

    assert_advance_R4: assert property (@(posedge clk) disable iff (rst)
        (data_wr && !sel_wr && (int'(idx_phase) < STORED)) |=>
            (($stable(idx_phase) && ({1'b0, idx_pair} == {1'b0, $past(idx_pair)} + 1'b1))
          || ((idx_pair == '0) && ({1'b0, idx_phase} == {1'b0, $past(idx_phase)} + 1'b1))));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!sel_wr && !data_wr) |=> $stable(idx_phase) && $stable(idx_pair) && $stable(idx_type));

    assert_past_end_R7: assert property (@(posedge clk) disable iff (rst)
        (!sel_wr && (int'(idx_phase) >= STORED)) |=>
            $stable(idx_phase) && $stable(idx_pair) && $stable(idx_type));

    assert_low_bits_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_even[LSB_ZERO-1:0] == '0) && (rd_odd[LSB_ZERO-1:0] == '0));

    assert_oob_read_R8: assert property (@(posedge clk) disable iff (rst)
        (int'(rd_phase) >= STORED) |=> (rd_even == '0) && (rd_odd == '0));

endmodule

bind coef_ram_loader cram_checker #(
    .STORED   (STORED),
    .PHASE_W  (PHASE_W),
    .PAIR_W   (PAIR_W),
    .COEF_W   (COEF_W),
    .LSB_ZERO (LSB_ZERO)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .sel_wr    (sel_wr),
    .sel_type  (sel_type),
    .sel_phase (sel_phase),
    .sel_pair  (sel_pair),
    .data_wr   (data_wr),
    .rd_phase  (rd_phase),
    .rd_even   (rd_even),
    .rd_odd    (rd_odd),
    .idx_type  (idx_type),
    .idx_phase (idx_phase),
    .idx_pair  (idx_pair)
);

// File: tb/coef_ram_loader_tb.sv
`timescale 1ns/1ps
module coef_ram_loader_tb_top;

    localparam int CW    = 14;
    localparam int NST   = 33;
    localparam int NPR   = 4;
    localparam logic [CW-1:0] MASK = 14'h3FFC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_wr = 0;
    logic [1:0]  sel_type = 0;
    logic [5:0]  sel_phase = 0;
    logic [1:0]  sel_pair = 0;
    logic        tap_wr = 0;
    logic [11:0] tap_data = 0;
    logic        data_wr = 0;
    logic [CW-1:0] even_coef = 0, odd_coef = 0;
    logic        even_en = 0, odd_en = 0;
    logic [1:0]  rd_type = 0;
    logic [5:0]  rd_phase = 0;
    logic [1:0]  rd_pair = 0;
    logic [CW-1:0] rd_even, rd_odd;

    always #2 clk = ~clk;   // 250 MHz

    coef_ram_loader dut_i (
        .clk(clk), .rst(rst),
        .sel_wr(sel_wr), .sel_type(sel_type), .sel_phase(sel_phase), .sel_pair(sel_pair),
        .tap_wr(tap_wr), .tap_data(tap_data),
        .data_wr(data_wr), .even_coef(even_coef), .even_en(even_en),
        .odd_coef(odd_coef), .odd_en(odd_en),
        .rd_type(rd_type), .rd_phase(rd_phase), .rd_pair(rd_pair),
        .rd_even(rd_even), .rd_odd(rd_odd)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // Reference model state
    int m_tap [4];
    int m_type, m_phase, m_pair;
    logic [CW-1:0] ex_e [4][NST][NPR];
    logic [CW-1:0] ex_o [4][NST][NPR];

    function automatic void model_reset();
        for (int t = 0; t < 4; t++) begin
            m_tap[t] = 7;
            for (int p = 0; p < NST; p++)
                for (int q = 0; q < NPR; q++) begin
                    ex_e[t][p][q] = '0;
                    ex_o[t][p][q] = '0;
                end
        end
        m_type = 0; m_phase = 0; m_pair = 0;
    endfunction

    function automatic void model_write(logic [CW-1:0] ev, bit ee, logic [CW-1:0] od, bit oe);
        int np;
        if (m_phase >= NST) return;                      // R7
        np = m_tap[m_type] / 2 + 1;                      // R4
        if (ee) ex_e[m_type][m_phase][m_pair] = ev & MASK;
        if (oe) ex_o[m_type][m_phase][m_pair] =
                ((m_tap[m_type] % 2 == 0) && (m_pair == np - 1)) ? '0 : (od & MASK); // R5
        if (m_pair + 1 >= np) begin m_pair = 0; m_phase++; end
        else m_pair++;
    endfunction

    task automatic do_sel(int t, int p, int q);
        sel_wr = 1; sel_type = 2'(t); sel_phase = 6'(p); sel_pair = 2'(q);
        @(negedge clk);
        sel_wr = 0;
        m_type = t; m_phase = p; m_pair = q;
    endtask

    task automatic do_data(logic [CW-1:0] ev, bit ee, logic [CW-1:0] od, bit oe);
        data_wr = 1; even_coef = ev; even_en = ee; odd_coef = od; odd_en = oe;
        @(negedge clk);
        data_wr = 0;
        model_write(ev, ee, od, oe);
    endtask

    // Select and pair write collide: only the select takes effect (R2)
    task automatic do_sel_collide(int t, int p, int q, logic [CW-1:0] ev, logic [CW-1:0] od);
        sel_wr = 1; sel_type = 2'(t); sel_phase = 6'(p); sel_pair = 2'(q);
        data_wr = 1; even_coef = ev; even_en = 1; odd_coef = od; odd_en = 1;
        @(negedge clk);
        sel_wr = 0; data_wr = 0;
        m_type = t; m_phase = p; m_pair = q;
    endtask

    task automatic do_taps(int f0, int f1, int f2, int f3);
        tap_wr = 1; tap_data = {3'(f3), 3'(f2), 3'(f1), 3'(f0)};
        @(negedge clk);
        tap_wr = 0;
        m_tap[0] = f0; m_tap[1] = f1; m_tap[2] = f2; m_tap[3] = f3;
    endtask

    task automatic check(string tag, logic [CW-1:0] ae, logic [CW-1:0] ao,
                         logic [CW-1:0] ee, logic [CW-1:0] eo);
        n_chk++;
        if (ae !== ee || ao !== eo) begin
            n_bad++;
            $display("FAIL %s: actual even=%h odd=%h expected even=%h odd=%h", tag, ae, ao, ee, eo);
        end
    endtask

    task automatic rd_chk(string tag, int t, int p, int q);
        logic [CW-1:0] ee, eo;
        rd_type = 2'(t); rd_phase = 6'(p); rd_pair = 2'(q);
        @(posedge clk); #1;
        if (p < NST) begin ee = ex_e[t][p][q]; eo = ex_o[t][p][q]; end
        else begin ee = '0; eo = '0; end
        check(tag, rd_even, rd_odd, ee, eo);
        @(negedge clk);
    endtask

    task automatic read_all(string tag);
        for (int t = 0; t < 4; t++)
            for (int p = 0; p < NST; p++)
                for (int q = 0; q < NPR; q++)
                    rd_chk(tag, t, p, q);
    endtask

    initial begin
        logic [CW-1:0] pe, po;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (4) @(negedge clk);
        rst = 0;

        // R1: reset contents, registers held at reset value right after release
        check("R1 output after reset", rd_even, rd_odd, '0, '0);
        rd_chk("R1 zero after reset", 0, 0, 0);
        rd_chk("R1 zero after reset", 3, 32, 3);
        rd_chk("R1 zero after reset", 2, 17, 1);

        // R1/R4: default tap count gives 4 pairs per phase
        for (int i = 0; i < 5; i++) do_data(CW'(16'h1000 + i * 16'h0104), 1, CW'(16'h2000 + i * 16'h0044), 1);
        rd_chk("R1 default pairs p0q3", 0, 0, 3);
        rd_chk("R4 fifth word wraps to phase 1", 0, 1, 0);
        rd_chk("R6 low bits cleared", 0, 0, 1);

        // R2: collision drops the pair word
        do_sel_collide(1, 5, 2, 14'h1555, 14'h0AAA);
        rd_chk("R2 collided word dropped", 1, 5, 2);
        do_data(14'h0F0F, 1, 14'h30F3, 1);
        rd_chk("R2 write at selected pointer", 1, 5, 2);
        rd_chk("R2 neighbour untouched", 1, 5, 1);
        rd_chk("R9 other type untouched", 0, 5, 2);

        // R3: per-half enables
        do_sel(2, 3, 1);
        do_data(14'h1234, 1, 14'h2345, 0);
        do_sel(2, 3, 1);
        do_data(14'h3456, 0, 14'h0567, 1);
        rd_chk("R3 half enables", 2, 3, 1);
        do_sel(2, 3, 1);
        do_data(14'h3FFF, 0, 14'h3FFF, 0);
        rd_chk("R3 both enables off", 2, 3, 1);

        // R5: 5 taps (field 4) on chroma vertical -> 3 pairs, last odd forced zero
        do_taps(7, 7, 7, 4);
        do_sel(3, 0, 0);
        for (int i = 0; i < 4; i++) do_data(CW'(16'h0800 + i * 16'h0110), 1, CW'(16'h1F00 + i * 16'h0010), 1);
        rd_chk("R5 last odd half zero", 3, 0, 2);
        rd_chk("R5 earlier pair keeps odd", 3, 0, 1);
        rd_chk("R4 three pairs then next phase", 3, 1, 0);
        rd_chk("R4 pair 3 unused", 3, 0, 3);

        // R7: run past phase 32, then select an out-of-range phase
        do_sel(0, 32, 3);
        do_data(14'h2468, 1, 14'h1357, 1);
        do_data(14'h3FFC, 1, 14'h3FFC, 1);
        do_data(14'h3FFC, 1, 14'h3FFC, 1);
        rd_chk("R7 last stored entry", 0, 32, 3);
        rd_chk("R7 no wrap into phase 0", 0, 0, 0);
        do_sel(0, 40, 0);
        do_data(14'h3FFC, 1, 14'h3FFC, 1);
        do_data(14'h3FFC, 1, 14'h3FFC, 1);
        do_sel(0, 0, 0);
        do_data(14'h0444, 1, 14'h0888, 1);
        rd_chk("R7 pointer resumes after select", 0, 0, 0);
        rd_chk("R7 phase 0 pair1 untouched", 0, 0, 1);

        // R8: out-of-range read, and one-cycle latency
        rd_chk("R8 out of range read zero", 0, 33, 0);
        rd_chk("R8 out of range read zero", 1, 63, 3);
        rd_chk("R8 latency first", 0, 32, 3);
        rd_type = 2'd1; rd_phase = 6'd5; rd_pair = 2'd2;
        #1;
        check("R8 output held before edge", rd_even, rd_odd, ex_e[0][32][3], ex_o[0][32][3]);
        @(posedge clk); #1;
        check("R8 output after edge", rd_even, rd_odd, ex_e[1][5][2], ex_o[1][5][2]);
        @(negedge clk);

        // Random fills of whole banks with random tap counts (R3 R4 R5 R6 R9)
        for (int round = 0; round < 2; round++) begin
            for (int t = 0; t < 4; t++) begin
                int f [4];
                for (int k = 0; k < 4; k++) f[k] = m_tap[k];
                f[t] = int'($urandom % 8);
                do_taps(f[0], f[1], f[2], f[3]);
                do_sel(t, 0, 0);
                for (int w = 0; w < NST * (f[t] / 2 + 1); w++) begin
                    pe = CW'($urandom); po = CW'($urandom);
                    do_data(pe, ($urandom % 8) != 0, po, ($urandom % 8) != 0);
                end
                // a stray write past the end must be ignored
                do_data(CW'($urandom), 1, CW'($urandom), 1);
            end
            read_all("R9 full readback after random fill");
        end

        // Random pointer placement and short bursts (R2 R4)
        for (int i = 0; i < 40; i++) begin
            do_sel(int'($urandom % 4), int'($urandom % 36), int'($urandom % 4));
            for (int w = 0; w < int'($urandom % 6); w++)
                do_data(CW'($urandom), 1, CW'($urandom), ($urandom % 2) != 0);
        end
        read_all("R4 readback after random bursts");

        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule